// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge Sequencer

This block joins two eight-input priority resolvers, one as the master and one as the slave, and drives a single interrupt line to a processor. Sixteen request lines come in: global lines 0 to 7 feed the master and lines 8 to 15 feed the slave. Master input 2 is not taken from the outside. It is the cascade input. Whenever the slave has a request it could deliver, the cascade input sees a fresh edge, so the master records a request on input 2.

The processor acknowledges through a valid/ready request channel. One accepted acknowledge produces one response on a valid/ready response channel. The response carries an 8-bit vector number, the global line that was acknowledged, and a spurious flag. A vector is built from the upper five bits of the relevant controller's base, with the 3-bit input number below them. When the master winner is the cascade input, the slave is acknowledged as well. When a controller has nothing deliverable at the moment of acknowledge, the response falls back to that controller's input 7 and that controller is left untouched. The vector bases, the per-line trigger modes and the masks are plain input pins. An end-of-interrupt strobe with a line number clears in-service state.

Top module: `cascade_intack_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `cpu_int` and `vec_valid` are 0 and `ack_ready` is 1. No request or in-service state is held.
- R2: A line whose `level_sel` bit is 0 raises a request on a 0-to-1 transition. Holding it high after it has been acknowledged and ended does not raise a second request.
- R3: A line whose `level_sel` bit is 1 requests for as long as it is high, and an acknowledge does not clear that request. When the line is still high after end-of-interrupt, it is delivered again. When it is low, no request remains.
- R4: Within one controller, input 0 has the highest priority and input 7 the lowest. A line whose mask bit is 1 is not delivered, but its latched request is delivered once the line is unmasked. A line in service blocks requests of equal and lower priority on its own controller.
- R5: `cpu_int` is 1 exactly when the master has a deliverable request. Because slave requests enter at master input 2, the overall order is: lines 0 and 1, then 8 to 15, then 3 to 7.
- R6: A deliverable slave request sets the request on master input 2, and this does not depend on `irq_lines[2]`.
- R7: When an acknowledge finds the master winner on input k, where k is not 2, the response has `vec_num = {base_m[7:3], k}`, `vec_line = k` and `vec_spurious = 0`. Line k is then in service on the master.
- R8: When an acknowledge finds the master winner on input 2 and the slave winner on input j, both are put in service. The response has `vec_num = {base_s[7:3], j}`, `vec_line = 8 + j` and `vec_spurious = 0`.
- R9: When an acknowledge finds the master winner on input 2 but the slave has nothing deliverable, the response has `vec_num = {base_s[7:3], 3'd7}`, `vec_line = 15` and `vec_spurious = 1`. Master input 2 goes in service and the slave state is unchanged.
- R10: When an acknowledge finds nothing deliverable on the master, the response has `vec_num = {base_m[7:3], 3'd7}`, `vec_line = 7` and `vec_spurious = 1`. The master state is unchanged.
- R11: An acknowledge is accepted in a cycle where `ack_valid` and `ack_ready` are both 1. The response is valid in the next cycle. `cpu_int` in that next cycle already reflects the updated in-service state.
- R12: Back-pressure rules: `ack_ready` is 0 while a response is held with `vec_ready` at 0. A held response keeps its values until it is taken. A response is taken in a cycle where `vec_valid` and `vec_ready` are both 1.
- R13: A strobe on `eoi_valid` clears the in-service bit of global line `eoi_line`. Values 0 to 7 address the master and 8 to 15 address the slave. After a slave line is ended, master input 2 must be ended separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 16 | Request lines; bit 2 is unused (cascade) |
| level_sel | input | 16 | Per line: 1 = level-sensitive, 0 = rising-edge |
| mask_m | input | 8 | Master input masks |
| mask_s | input | 8 | Slave input masks |
| base_m | input | 8 | Master vector base (low 3 bits ignored) |
| base_s | input | 8 | Slave vector base (low 3 bits ignored) |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be accepted |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 4 | Global line to end |
| cpu_int | output | 1 | Interrupt line to the processor |
| vec_valid | output | 1 | Response valid |
| vec_ready | input | 1 | Response consumer ready |
| vec_num | output | 8 | Vector number |
| vec_line | output | 4 | Acknowledged global line |
| vec_spurious | output | 1 | Response is a spurious fallback |

## Verification
The hardest case to reach is the spurious fallback on the slave. The master must have latched a cascade request, and the slave must then lose it before the acknowledge arrives. The stimulus holds a level-sensitive slave line high until the cascade request is latched on master input 2, then drops the line, and only then acknowledges. A later pulse on line 15 that comes back non-spurious shows that the fallback left no slave in-service bit behind. The other checks sweep every single line and every pair of lines against a computed global priority order.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int CTRL_INPUTS = 8;
  localparam int IDX_W       = $clog2(CTRL_INPUTS);
  localparam int LINE_W      = IDX_W + 1;
  localparam int VEC_W       = 8;
  localparam int CASC_INPUT  = 2;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    logic             spur;
    logic [VEC_W-1:0] num;
    line_t            line;
  } vec_rsp_t;
endpackage

// File: rtl/cascade_prio_pick.sv
module cascade_prio_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Lowest set index wins.
  always_comb begin
    any = |bits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cascade_resolver.sv
module cascade_resolver #(
  parameter int         N         = 8,
  parameter logic [N-1:0] EDGE_ONLY = '0,
  localparam int        IW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  level_sel,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  force_set,
  input  logic          ack_en,
  input  logic [IW-1:0] ack_idx,
  input  logic          eoi_en,
  input  logic [IW-1:0] eoi_idx,
  output logic          pend,
  output logic [IW-1:0] win
);
  logic [N-1:0] irr_q, isr_q, last_q;
  logic [N-1:0] irr_d, isr_d, ack_oh, eoi_oh, lvl_eff;
  logic          req_any, isr_any;
  logic [IW-1:0] req_idx, isr_idx;

  cascade_prio_pick #(.N(N)) u_pick_req (
    .bits (irr_q & ~mask),
    .any  (req_any),
    .idx  (req_idx)
  );

  cascade_prio_pick #(.N(N)) u_pick_isr (
    .bits (isr_q),
    .any  (isr_any),
    .idx  (isr_idx)
  );

  assign pend = req_any && (!isr_any || (req_idx < isr_idx));
  assign win  = req_idx;

  assign ack_oh  = ack_en ? (N'(1) << ack_idx) : '0;
  assign eoi_oh  = eoi_en ? (N'(1) << eoi_idx) : '0;
  assign lvl_eff = level_sel & ~EDGE_ONLY;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (lvl_eff[i]) begin
        irr_d[i] = req[i];
      end else begin
        irr_d[i] = (irr_q[i] | (req[i] & ~last_q[i]) | force_set[i]) & ~ack_oh[i];
      end
    end
    isr_d = (isr_q | ack_oh) & ~eoi_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      last_q <= req & ~EDGE_ONLY;
    end
  end
endmodule

// File: rtl/cascade_ack_ctrl.sv
module cascade_ack_ctrl
  import cascade_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  output logic             ack_ready,
  input  logic             vec_ready,
  input  logic             m_pend,
  input  idx_t             m_win,
  input  logic             s_pend,
  input  idx_t             s_win,
  input  logic [VEC_W-1:0] base_m,
  input  logic [VEC_W-1:0] base_s,
  output logic             m_ack_en,
  output idx_t             m_ack_idx,
  output logic             s_ack_en,
  output idx_t             s_ack_idx,
  output logic             vec_valid,
  output vec_rsp_t         vec_q
);
  localparam idx_t SPUR_IDX = idx_t'(CTRL_INPUTS - 1);
  localparam idx_t CASC_IDX = idx_t'(CASC_INPUT);

  logic     fire;
  vec_rsp_t rsp_d;

  assign ack_ready = !vec_valid || vec_ready;
  assign fire      = ack_valid && ack_ready;
  assign m_ack_idx = m_win;
  assign s_ack_idx = s_win;

  always_comb begin
    m_ack_en = 1'b0;
    s_ack_en = 1'b0;
    rsp_d    = '0;
    if (!m_pend) begin
      rsp_d.spur = 1'b1;
      rsp_d.num  = {base_m[VEC_W-1:IDX_W], SPUR_IDX};
      rsp_d.line = {1'b0, SPUR_IDX};
    end else if (m_win != CASC_IDX) begin
      m_ack_en   = fire;
      rsp_d.num  = {base_m[VEC_W-1:IDX_W], m_win};
      rsp_d.line = {1'b0, m_win};
    end else begin
      m_ack_en = fire;
      if (s_pend) begin
        s_ack_en   = fire;
        rsp_d.num  = {base_s[VEC_W-1:IDX_W], s_win};
        rsp_d.line = {1'b1, s_win};
      end else begin
        rsp_d.spur = 1'b1;
        rsp_d.num  = {base_s[VEC_W-1:IDX_W], SPUR_IDX};
        rsp_d.line = {1'b1, SPUR_IDX};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_q     <= '0;
    end else if (fire) begin
      vec_valid <= 1'b1;
      vec_q     <= rsp_d;
    end else if (vec_ready) begin
      vec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cascade_intack_top.sv
module cascade_intack_top
  import cascade_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*CTRL_INPUTS-1:0]  irq_lines,
  input  logic [2*CTRL_INPUTS-1:0]  level_sel,
  input  logic [CTRL_INPUTS-1:0]    mask_m,
  input  logic [CTRL_INPUTS-1:0]    mask_s,
  input  logic [VEC_W-1:0]          base_m,
  input  logic [VEC_W-1:0]          base_s,
  input  logic                      ack_valid,
  output logic                      ack_ready,
  input  logic                      eoi_valid,
  input  logic [LINE_W-1:0]         eoi_line,
  output logic                      cpu_int,
  output logic                      vec_valid,
  input  logic                      vec_ready,
  output logic [VEC_W-1:0]          vec_num,
  output logic [LINE_W-1:0]         vec_line,
  output logic                      vec_spurious
);
  localparam logic [CTRL_INPUTS-1:0] CASC_BIT = CTRL_INPUTS'(1) << CASC_INPUT;

  logic     m_pend, s_pend, m_ack_en, s_ack_en;
  idx_t     m_win, s_win, m_ack_idx, s_ack_idx;
  vec_rsp_t vec_q;
  logic [CTRL_INPUTS-1:0] m_req, m_force;

  // Cascade input: an edge is seen every cycle the slave can deliver.
  assign m_req   = irq_lines[CTRL_INPUTS-1:0] & ~CASC_BIT;
  assign m_force = s_pend ? CASC_BIT : '0;

  cascade_resolver #(.N(CTRL_INPUTS), .EDGE_ONLY(CASC_BIT)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (m_req),
    .level_sel (level_sel[CTRL_INPUTS-1:0]),
    .mask      (mask_m),
    .force_set (m_force),
    .ack_en    (m_ack_en),
    .ack_idx   (m_ack_idx),
    .eoi_en    (eoi_valid && !eoi_line[IDX_W]),
    .eoi_idx   (eoi_line[IDX_W-1:0]),
    .pend      (m_pend),
    .win       (m_win)
  );

  cascade_resolver #(.N(CTRL_INPUTS), .EDGE_ONLY('0)) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (irq_lines[2*CTRL_INPUTS-1:CTRL_INPUTS]),
    .level_sel (level_sel[2*CTRL_INPUTS-1:CTRL_INPUTS]),
    .mask      (mask_s),
    .force_set ('0),
    .ack_en    (s_ack_en),
    .ack_idx   (s_ack_idx),
    .eoi_en    (eoi_valid && eoi_line[IDX_W]),
    .eoi_idx   (eoi_line[IDX_W-1:0]),
    .pend      (s_pend),
    .win       (s_win)
  );

  cascade_ack_ctrl u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ack_ready (ack_ready),
    .vec_ready (vec_ready),
    .m_pend    (m_pend),
    .m_win     (m_win),
    .s_pend    (s_pend),
    .s_win     (s_win),
    .base_m    (base_m),
    .base_s    (base_s),
    .m_ack_en  (m_ack_en),
    .m_ack_idx (m_ack_idx),
    .s_ack_en  (s_ack_en),
    .s_ack_idx (s_ack_idx),
    .vec_valid (vec_valid),
    .vec_q     (vec_q)
  );

  assign cpu_int      = m_pend;
  assign vec_num      = vec_q.num;
  assign vec_line     = vec_q.line;
  assign vec_spurious = vec_q.spur;
endmodule

// File: rtl/cascade_intack_chk.sv
module cascade_intack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_valid,
  input logic       ack_ready,
  input logic       cpu_int,
  input logic       vec_valid,
  input logic       vec_ready,
  input logic [7:0] vec_num,
  input logic [3:0] vec_line,
  input logic       vec_spurious
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!vec_valid && !cpu_int));

  assert_rsp_follows_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> vec_valid);

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_num) && $stable(vec_line)
                                   && $stable(vec_spurious)));

  assert_no_cascade_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_line != 4'd2));

  assert_index_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_spurious) |-> (vec_num[2:0] == vec_line[2:0]));

  assert_spur_slave_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_spurious && vec_line[3]) |-> (vec_line == 4'd15 && vec_num[2:0] == 3'd7));

  assert_spur_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_spurious && !vec_line[3]) |-> (vec_line == 4'd7 && vec_num[2:0] == 3'd7));
endmodule

bind cascade_intack_top cascade_intack_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_valid    (ack_valid),
  .ack_ready    (ack_ready),
  .cpu_int      (cpu_int),
  .vec_valid    (vec_valid),
  .vec_ready    (vec_ready),
  .vec_num      (vec_num),
  .vec_line     (vec_line),
  .vec_spurious (vec_spurious)
);

// File: tb/cascade_intack_top_tb.sv
module cascade_intack_top_tb;
  localparam logic [7:0] BM = 8'h25;
  localparam logic [7:0] BS = 8'h7B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] irq_lines = '0, level_sel = '0;
  logic [7:0] mask_m = '0, mask_s = '0;
  logic       ack_valid = 1'b0, eoi_valid = 1'b0, vec_ready = 1'b1;
  logic [3:0] eoi_line = '0;
  logic       ack_ready, cpu_int, vec_valid, vec_spurious;
  logic [7:0] vec_num;
  logic [3:0] vec_line;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cascade_intack_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .level_sel(level_sel),
    .mask_m(mask_m), .mask_s(mask_s), .base_m(BM), .base_s(BS),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .eoi_valid(eoi_valid),
    .eoi_line(eoi_line), .cpu_int(cpu_int), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_num(vec_num), .vec_line(vec_line),
    .vec_spurious(vec_spurious)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rank(input int l);
    if (l < 2) return l;
    if (l < 8) return l + 8;
    return l - 6;
  endfunction

  function automatic int exp_vec(input int l);
    if (l < 8) return {BM[7:3], 3'(l)};
    return {BS[7:3], 3'(l - 8)};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int l);
    @(negedge clk);
    irq_lines[l] = 1'b1;
    @(negedge clk);
    irq_lines[l] = 1'b0;
  endtask

  task automatic eoi(input int l);
    @(negedge clk);
    eoi_valid = 1'b1;
    eoi_line  = 4'(l);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic eoi_full(input int l);
    eoi(l);
    if (l >= 8) eoi(2);
  endtask

  // Acknowledge and check the response in the cycle after acceptance.
  task automatic ack_expect(input int line, input bit spur, input string tag);
    @(negedge clk);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    check(vec_valid == 1'b1, {tag, " R11 valid"}, int'(vec_valid), 1);
    check(int'(vec_line) == line, {tag, " line"}, int'(vec_line), line);
    check(int'(vec_num) == exp_vec(line), {tag, " vec"}, int'(vec_num), exp_vec(line));
    check(vec_spurious == spur, {tag, " spurious"}, int'(vec_spurious), int'(spur));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(!cpu_int && !vec_valid && ack_ready, "R1 reset", int'(cpu_int), 0);
    rst_n = 1'b1;
    idle(1);
    check(!cpu_int && !vec_valid && ack_ready, "R1 after release", int'(vec_valid), 0);

    // R10: master spurious, then line 7 still deliverable
    ack_expect(7, 1'b1, "R10 master spurious");
    pulse(7); idle(2);
    check(cpu_int, "R10 master untouched", int'(cpu_int), 1);
    ack_expect(7, 1'b0, "R10 line7 after spurious");
    eoi(7);

    // Single-line sweep (R5, R6, R7, R8, R11)
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      pulse(l); idle(3);
      check(cpu_int, (l >= 8) ? "R6 cascade request" : "R5 request", int'(cpu_int), 1);
      ack_expect(l, 1'b0, (l >= 8) ? "R8 slave ack" : "R7 master ack");
      check(!cpu_int, "R11 int drops after ack", int'(cpu_int), 0);
      eoi_full(l); idle(3);
      check(!cpu_int, "R13 idle after eoi", int'(cpu_int), 0);
    end

    // R6: irq_lines[2] has no effect
    pulse(2); idle(3);
    check(!cpu_int, "R6 pin 2 ignored", int'(cpu_int), 0);

    // Pair sweep (R4, R5, R13)
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        int first, second;
        if (a == 2 || b == 2) continue;
        first  = (rank(a) < rank(b)) ? a : b;
        second = (first == a) ? b : a;
        @(negedge clk);
        irq_lines[a] = 1'b1; irq_lines[b] = 1'b1;
        @(negedge clk);
        irq_lines[a] = 1'b0; irq_lines[b] = 1'b0;
        idle(3);
        ack_expect(first, 1'b0, "R5 pair winner");
        check(!cpu_int, "R4 in-service blocks lower", int'(cpu_int), 0);
        eoi_full(first); idle(3);
        check(cpu_int, "R13 eoi reopens", int'(cpu_int), 1);
        ack_expect(second, 1'b0, "R4 pair second");
        eoi_full(second); idle(3);
        check(!cpu_int, "R13 pair idle", int'(cpu_int), 0);
      end
    end

    // R4 masking on both controllers
    mask_m[3] = 1'b1; pulse(3); idle(3);
    check(!cpu_int, "R4 master mask", int'(cpu_int), 0);
    mask_m[3] = 1'b0; idle(2);
    check(cpu_int, "R4 master unmask", int'(cpu_int), 1);
    ack_expect(3, 1'b0, "R4 masked line later");
    eoi(3);
    mask_s[1] = 1'b1; pulse(9); idle(3);
    check(!cpu_int, "R4 slave mask", int'(cpu_int), 0);
    mask_s[1] = 1'b0; idle(3);
    check(cpu_int, "R4 slave unmask", int'(cpu_int), 1);
    ack_expect(9, 1'b0, "R4 slave masked later");
    eoi_full(9);

    // R2: edge line held high requests once
    @(negedge clk); irq_lines[4] = 1'b1; idle(3);
    ack_expect(4, 1'b0, "R2 held edge");
    eoi(4); idle(3);
    check(!cpu_int, "R2 no re-request", int'(cpu_int), 0);
    irq_lines[4] = 1'b0;

    // R3: level line re-requests while high
    level_sel[10] = 1'b1;
    @(negedge clk); irq_lines[10] = 1'b1; idle(4);
    ack_expect(10, 1'b0, "R3 level first");
    eoi_full(10); idle(3);
    check(cpu_int, "R3 level re-request", int'(cpu_int), 1);
    ack_expect(10, 1'b0, "R3 level second");
    @(negedge clk); irq_lines[10] = 1'b0; idle(2);
    eoi_full(10); idle(3);
    check(!cpu_int, "R3 level dropped", int'(cpu_int), 0);
    level_sel[10] = 1'b0;

    // R9: slave spurious via vanishing level request
    level_sel[12] = 1'b1;
    @(negedge clk); irq_lines[12] = 1'b1; idle(4);
    irq_lines[12] = 1'b0; idle(3);
    check(cpu_int, "R9 cascade latched", int'(cpu_int), 1);
    ack_expect(15, 1'b1, "R9 slave spurious");
    check(!cpu_int, "R9 master 2 in service", int'(cpu_int), 0);
    eoi(2); level_sel[12] = 1'b0;
    pulse(15); idle(3);
    check(cpu_int, "R9 slave untouched", int'(cpu_int), 1);
    ack_expect(15, 1'b0, "R9 line15 real");
    eoi_full(15);

    // R12: back-pressure
    @(negedge clk); vec_ready = 1'b0;
    pulse(5); pulse(6); idle(2);
    ack_expect(5, 1'b0, "R12 held response");
    idle(1);
    check(!ack_ready, "R12 ready low", int'(ack_ready), 0);
    ack_valid = 1'b1; idle(2); ack_valid = 1'b0;
    check(vec_valid && vec_line == 4'd5, "R12 held stable", int'(vec_line), 5);
    vec_ready = 1'b1; idle(1);
    check(!vec_valid, "R12 drained", int'(vec_valid), 0);
    eoi(5); idle(2);
    ack_expect(6, 1'b0, "R12 next after drain");
    eoi(6);

    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule